// File: doc/BRIEF.md
# Four-Channel Converter Serial Register Front End

This block is the digital side of a four-channel converter. A host writes it over a three-wire serial link: an active-low select, a serial clock and a data line. Each write names one of four channels and carries a 14-bit code. The code first lands in that channel's staging register. A separate active-low, level-sensitive load strobe then copies all four staging registers into the four output registers together, so every channel can change in the same cycle. A serial output repeats the bits that were shifted in, delayed, so that several devices can share one select and be chained.

All serial and strobe inputs are brought into a single system clock domain through two-flop synchronizers, and edges are found there. Two active-low asynchronous resets are provided. One is the power-up reset, which also clears the synchronizers and the shift register. The other is the preset pin. Both drive the staging and output registers to a preset code, which a strap input picks: zero or half scale.

Top module: `quad_dac_frontend`

## Requirements
- R1: A frame is shifted in MSB first. The bit order is a 2-bit channel address, then two ignored bits, then code bit 13 down to bit 0. A bit is taken only on a rising edge of the serial clock while the select is low.
- R2: While the select is high, serial clock edges do not move the shift register, and the serial output does not change.
- R3: On a select rising edge only the 18 most recent bits are used. Leading bits beyond 18, for example in a 24-bit transfer, have no effect.
- R4: A select rising edge writes the 14-bit code into the staging register of the addressed channel only. The address maps 0, 1, 2 and 3 to channels A, B, C and D. Channel i occupies bits [14*i+13:14*i] of `dacCodes`.
- R5: While the load strobe is low, every output register takes its staging register value on each clock. While the strobe is high, the output registers hold their value.
- R6: While `presetN` is low, every staging and output register is forced asynchronously to the preset code. The preset code is 0x0000 when `presetHalf` is 0 and 0x2000 when it is 1.
- R7: The power-up reset applies the same preset code. The registers keep that code until a serial load and a load strobe change them.
- R8: The serial output is the bit shifted in 18 serial clock rising edges earlier. It changes on the system clock edge that performs the shift.
- R9: A frame shorter than 18 bits still latches, on the select rising edge, whatever the 18-bit shift register then holds. Address and code are taken from that content.
- R10: A preset that is active during a select rising edge or a low load strobe overrides both. After the preset is released, the registers still hold the preset code.
- R11: A select rising edge at the pin is written into the staging register on the third system clock rising edge. With the load strobe low, the output register shows the new code one system clock edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-up reset, active low, asynchronous |
| presetN | input | 1 | Preset request, active low, asynchronous |
| presetHalf | input | 1 | Strap: 1 selects half-scale preset, 0 selects zero |
| serClk | input | 1 | Serial clock, data taken on its rising edge |
| serCsN | input | 1 | Serial select, active low; its rising edge latches the frame |
| serDin | input | 1 | Serial data in |
| serDout | output | 1 | Serial data out for chaining |
| loadN | input | 1 | Load strobe, active low, level sensitive |
| dacCodes | output | 56 | Four 14-bit output register values, channel A in the low bits |

## Verification
The hardest case to reach from the ports is exact cycle placement. The question is which system clock edge turns a pin transition into a register write, since every path crosses two synchronizer stages and an edge detector. A behavioural model in the bench keeps a history of the sampled pin values. It reproduces the sync delay from that history and is compared with `dacCodes` and `serDout` on every clock. A directed step raises the select with the load strobe low and looks at the output on the third and fourth edges. Short frames, 24-bit frames, clock toggling with the select high, and a preset applied during a latch and a load are each driven on purpose.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  // One-cycle control strobes from the control unit to the datapath
  typedef struct packed {
    logic shiftEn;   // take one serial bit into the shift register
    logic latchEn;   // select rose: write the framed code to the addressed channel
    logic loadEn;    // load strobe is low: output registers follow staging
  } qdacStrobes_t;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RESET_VAL;
    end else begin
      pipe[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
(
  input  logic         clk,
  input  logic         porN,
  input  logic         clkSync,
  input  logic         csSync,
  input  logic         loadSync,
  output qdacStrobes_t strb
);

  logic clkPrev;
  logic csPrev;

  // Previous-sample registers for edge detection; idle levels on reset
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      clkPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      clkPrev <= clkSync;
      csPrev  <= csSync;
    end
  end

  always_comb begin
    strb = '0;
    strb.shiftEn = clkSync & ~clkPrev & ~csSync;
    strb.latchEn = csSync & ~csPrev;
    strb.loadEn  = ~loadSync;
  end

endmodule

// File: rtl/qdac_datapath.sv
module qdac_datapath
  import qdac_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 14,
  parameter int ADDR_W  = 2,
  parameter int FRAME_W = 18
) (
  input  logic                     clk,
  input  logic                     porN,
  input  logic                     presetN,
  input  logic                     presetHalf,
  input  qdacStrobes_t             strb,
  input  logic                     dinSync,
  output logic [FRAME_W-1:0]       shiftWord,
  output logic [NUM_CH*DATA_W-1:0] inRegsFlat,
  output logic [NUM_CH*DATA_W-1:0] dacFlat,
  output logic                     dout
);

  localparam logic [DATA_W-1:0] HALF_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] presetCode;
  logic              regRstN;
  logic [ADDR_W-1:0] frameAddr;
  logic [DATA_W-1:0] frameCode;

  assign presetCode = presetHalf ? HALF_CODE : '0;
  assign regRstN    = porN & presetN;
  assign frameAddr  = shiftWord[FRAME_W-1 -: ADDR_W];
  assign frameCode  = shiftWord[DATA_W-1:0];

  // Serial shift register: only power-up reset clears it
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      shiftWord <= '0;
    end else if (strb.shiftEn) begin
      shiftWord <= {shiftWord[FRAME_W-2:0], dinSync};
    end
  end

  assign dout = shiftWord[FRAME_W-1];

  // Per-channel staging and output registers
  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [DATA_W-1:0] stageReg;
    logic [DATA_W-1:0] outReg;
    logic              hit;

    assign hit = strb.latchEn && (frameAddr == ADDR_W'(g));

    always_ff @(posedge clk or negedge regRstN) begin
      if (!regRstN) begin
        stageReg <= presetCode;
      end else if (hit) begin
        stageReg <= frameCode;
      end
    end

    always_ff @(posedge clk or negedge regRstN) begin
      if (!regRstN) begin
        outReg <= presetCode;
      end else if (strb.loadEn) begin
        outReg <= stageReg;
      end
    end

    assign inRegsFlat[g*DATA_W +: DATA_W] = stageReg;
    assign dacFlat[g*DATA_W +: DATA_W]    = outReg;
  end

endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend
  import qdac_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 14,
  parameter int PAD_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     porN,
  input  logic                     presetN,
  input  logic                     presetHalf,
  input  logic                     serClk,
  input  logic                     serCsN,
  input  logic                     serDin,
  output logic                     serDout,
  input  logic                     loadN,
  output logic [NUM_CH*DATA_W-1:0] dacCodes
);

  localparam int ADDR_W  = $clog2(NUM_CH);
  localparam int FRAME_W = ADDR_W + PAD_W + DATA_W;
  localparam int PINS_W  = 4;

  logic [PINS_W-1:0]        pinSync;
  qdacStrobes_t             strb;
  logic [FRAME_W-1:0]       shiftWord;
  logic [NUM_CH*DATA_W-1:0] inRegsFlat;

  // Bit order: {serClk, serCsN, serDin, loadN}; idle levels on reset
  qdac_sync #(
    .WIDTH    (PINS_W),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(4'b0101)
  ) sync_i (
    .clk    (clk),
    .rstN   (porN),
    .asyncIn({serClk, serCsN, serDin, loadN}),
    .syncOut(pinSync)
  );

  qdac_ctrl ctrl_i (
    .clk     (clk),
    .porN    (porN),
    .clkSync (pinSync[3]),
    .csSync  (pinSync[2]),
    .loadSync(pinSync[0]),
    .strb    (strb)
  );

  qdac_datapath #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .FRAME_W(FRAME_W)
  ) dp_i (
    .clk       (clk),
    .porN      (porN),
    .presetN   (presetN),
    .presetHalf(presetHalf),
    .strb      (strb),
    .dinSync   (pinSync[1]),
    .shiftWord (shiftWord),
    .inRegsFlat(inRegsFlat),
    .dacFlat   (dacCodes),
    .dout      (serDout)
  );

endmodule

// File: rtl/qdac_checker.sv
module qdac_checker
  import qdac_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 14,
  parameter int FRAME_W = 18
) (
  input logic                     clk,
  input logic                     porN,
  input logic                     presetN,
  input logic                     presetHalf,
  input qdacStrobes_t             strb,
  input logic [FRAME_W-1:0]       shiftWord,
  input logic [NUM_CH*DATA_W-1:0] inRegsFlat,
  input logic [NUM_CH*DATA_W-1:0] dacFlat,
  input logic                     serDout
);

  logic [DATA_W-1:0] expPreset;
  assign expPreset = presetHalf ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

  // R6: preset drives every staging and output register to the strap code
  assert_preset_R6: assert property (@(posedge clk) disable iff (!porN)
    !presetN |-> (dacFlat == {NUM_CH{expPreset}}) && (inRegsFlat == {NUM_CH{expPreset}}));

  // R5: output registers hold while the load strobe is inactive
  assert_dac_hold_R5: assert property (@(posedge clk) disable iff (!porN || !presetN)
    !strb.loadEn |=> $stable(dacFlat));

  // R5: output registers copy staging while the load strobe is active
  assert_dac_follow_R5: assert property (@(posedge clk) disable iff (!porN || !presetN)
    strb.loadEn |=> dacFlat == $past(inRegsFlat));

  // R4: staging registers change only on a select rising edge
  assert_stage_stable_R4: assert property (@(posedge clk) disable iff (!porN || !presetN)
    !strb.latchEn |=> $stable(inRegsFlat));

  // R2: shift register frozen without a qualified shift
  assert_shift_frozen_R2: assert property (@(posedge clk) disable iff (!porN)
    !strb.shiftEn |=> $stable(shiftWord));

  // R8: serial output advances by one stage on each shift
  assert_dout_shift_R8: assert property (@(posedge clk) disable iff (!porN)
    strb.shiftEn |=> serDout == $past(shiftWord[FRAME_W-2]));

endmodule

bind quad_dac_frontend qdac_checker #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W),
  .FRAME_W(FRAME_W)
) chk_i (
  .clk       (clk),
  .porN      (porN),
  .presetN   (presetN),
  .presetHalf(presetHalf),
  .strb      (strb),
  .shiftWord (shiftWord),
  .inRegsFlat(inRegsFlat),
  .dacFlat   (dacCodes),
  .serDout   (serDout)
);

// File: tb/quad_dac_frontend_tb_top.sv
module quad_dac_frontend_tb_top;

  localparam int NCH = 4;
  localparam int DW  = 14;
  localparam int FW  = 18;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic porN, presetN, presetHalf, serClk, serCsN, serDin, loadN;
  logic serDout;
  logic [NCH*DW-1:0] dacCodes;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  quad_dac_frontend dut_i (
    .clk(clk), .porN(porN), .presetN(presetN), .presetHalf(presetHalf),
    .serClk(serClk), .serCsN(serCsN), .serDin(serDin), .serDout(serDout),
    .loadN(loadN), .dacCodes(dacCodes)
  );

  // ---------------- behavioural reference model ----------------
  // hX[k] holds the pin value seen k clock edges ago
  logic [FW-1:0] mShift;
  logic [DW-1:0] mIn  [NCH];
  logic [DW-1:0] mDac [NCH];
  logic hClk [1:3];
  logic hCs  [1:3];
  logic hDin [1:3];
  logic hLd  [1:3];
  logic [DW-1:0] mPre;
  logic shiftEv, latchEv;

  always @(posedge clk) begin
    mPre = presetHalf ? 14'h2000 : 14'h0000;
    if (!porN) begin
      mShift = '0;
      for (int k = 1; k <= 3; k++) begin
        hClk[k] = 1'b0; hCs[k] = 1'b1; hDin[k] = 1'b0; hLd[k] = 1'b1;
      end
      for (int c = 0; c < NCH; c++) begin mIn[c] = mPre; mDac[c] = mPre; end
    end else begin
      shiftEv = hClk[2] && !hClk[3] && !hCs[2];
      latchEv = hCs[2] && !hCs[3];
      if (!presetN) begin
        for (int c = 0; c < NCH; c++) begin mIn[c] = mPre; mDac[c] = mPre; end
      end else begin
        if (!hLd[2]) for (int c = 0; c < NCH; c++) mDac[c] = mIn[c];
        if (latchEv) mIn[mShift[FW-1 -: 2]] = mShift[DW-1:0];
      end
      if (shiftEv) mShift = {mShift[FW-2:0], hDin[2]};
      hClk[3] = hClk[2]; hClk[2] = hClk[1]; hClk[1] = serClk;
      hCs[3]  = hCs[2];  hCs[2]  = hCs[1];  hCs[1]  = serCsN;
      hDin[3] = hDin[2]; hDin[2] = hDin[1]; hDin[1] = serDin;
      hLd[3]  = hLd[2];  hLd[2]  = hLd[1];  hLd[1]  = loadN;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dacOf(int ch);
    return dacCodes[ch*DW +: DW];
  endfunction

  // Per-clock comparison, sampled after the edge has settled
  always @(posedge clk) begin
    #2;
    if (porN && !finished) begin
      for (int c = 0; c < NCH; c++) chk("R5", "model dac", 32'(dacOf(c)), 32'(mDac[c]));
      chk("R8", "model dout", 32'(serDout), 32'(mShift[FW-1]));
    end
  end

  // ---------------- stimulus ----------------
  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(logic [31:0] w, int n, bit closeCs);
    serCsN = 1'b0;
    waitN(4);
    for (int i = n - 1; i >= 0; i--) begin
      serDin = w[i];
      waitN(4);
      serClk = 1'b1;
      waitN(4);
      serClk = 1'b0;
    end
    waitN(4);
    if (closeCs) begin
      serCsN = 1'b1;
      waitN(6);
    end
  endtask

  function automatic logic [31:0] frm(logic [1:0] a, logic [1:0] pad, logic [13:0] d);
    return 32'({a, pad, d});
  endfunction

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  logic [FW-1:0] oldW, newW;
  logic keepDout;

  initial begin
    porN = 0; presetN = 1; presetHalf = 1; serClk = 0; serCsN = 1; serDin = 0; loadN = 1;
    waitN(5);
    porN = 1;
    waitN(3);
    // R7: power-up preset to half scale
    for (int c = 0; c < NCH; c++) chk("R7", "power-up half scale", 32'(dacOf(c)), 32'h2000);

    // R4 / R5: write A with load high, output holds
    sendBits(frm(2'b00, 2'b00, 14'h1234), 18, 1);
    chk("R5", "hold while load high", 32'(dacOf(0)), 32'h2000);
    chk("R7", "preset kept until load", 32'(dacOf(1)), 32'h2000);
    loadN = 0;
    waitN(4);
    chk("R5", "follow while load low", 32'(dacOf(0)), 32'h1234);
    chk("R4", "other channel untouched", 32'(dacOf(1)), 32'h2000);
    chk("R4", "channel D untouched", 32'(dacOf(3)), 32'h2000);

    // R3: 24-bit transfer with junk leading bits and set pad bits
    sendBits({8'h00, 6'b111111, 2'b10, 2'b11, 14'h3ABC}, 24, 1);
    waitN(2);
    chk("R3", "24-bit frame to C", 32'(dacOf(2)), 32'h3ABC);
    chk("R4", "A kept after C write", 32'(dacOf(0)), 32'h1234);

    // R11: exact edge placement of a select rising edge
    sendBits(frm(2'b01, 2'b00, 14'h0777), 18, 0);
    serCsN = 1'b1;
    repeat (3) @(posedge clk);
    #2 chk("R11", "B unchanged at third edge", 32'(dacOf(1)), 32'h2000);
    @(posedge clk);
    #2 chk("R11", "B updated at fourth edge", 32'(dacOf(1)), 32'h0777);
    waitN(4);

    // R1 / R8: frame to D, serial out shows the first bit (address MSB)
    sendBits(frm(2'b11, 2'b00, 14'h0155), 18, 1);
    chk("R1", "frame to D", 32'(dacOf(3)), 32'h0155);
    chk("R8", "dout after 18 bits", 32'(serDout), 32'h1);

    // R2: clock toggles with select high have no effect
    keepDout = serDout;
    serDin = 1'b0;
    for (int t = 0; t < 5; t++) begin
      serClk = 1'b1; waitN(4); serClk = 1'b0; waitN(4);
    end
    chk("R2", "dout frozen with select high", 32'(serDout), 32'(keepDout));

    // R9: short frame latches the shift register content as it stands
    oldW = {2'b11, 2'b00, 14'h0155};
    newW = {oldW[FW-5:0], 4'b1010};
    sendBits(32'h0000_000A, 4, 1);
    waitN(2);
    chk("R9", "short frame code", 32'(dacOf(int'(newW[FW-1 -: 2]))), 32'(newW[DW-1:0]));

    // R6: zero-scale preset, asynchronous
    presetHalf = 1'b0;
    presetN = 1'b0;
    #1;
    for (int c = 0; c < NCH; c++) chk("R6", "async zero preset", 32'(dacOf(c)), 32'h0);
    // R10: latch and low load during preset are overridden
    sendBits(frm(2'b00, 2'b00, 14'h0FFF), 18, 1);
    chk("R10", "A held during preset", 32'(dacOf(0)), 32'h0);
    presetN = 1'b1;
    waitN(4);
    chk("R10", "A still preset after release", 32'(dacOf(0)), 32'h0);
    chk("R10", "C still preset after release", 32'(dacOf(2)), 32'h0);

    // R1: asymmetric code checks bit order
    sendBits(frm(2'b01, 2'b00, 14'h2001), 18, 1);
    waitN(2);
    chk("R1", "MSB-first order to B", 32'(dacOf(1)), 32'h2001);

    loadN = 1'b1;
    waitN(4);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

endmodule